// File: doc/BRIEF.md
# Keyboard Wake Interrupt Controller

This block collects up to eight external input lines into one interrupt request. Software picks the lines that take part and gives each one a polarity. A line is active low or falling when its polarity bit is 0, and active high or rising when the bit is 1. One global mode bit chooses between two kinds of detection. In edge-only detection, a transition of an enabled line into its active level is an event. In edge-and-level detection, a line that is held at its active level also keeps producing events. Every event sets one shared status flag. The interrupt request is raised while that flag is set and the interrupt enable is on. Software clears the flag by writing a one to a self-clearing acknowledge bit.

The lines enter through a two-stage synchronizer. One shared detector then compares each synchronized sample with the sample from the cycle before. After the detector fires, it stays disarmed until every enabled line is back at its inactive level. Lines that are disabled take no part in detection and do not hold off re-arming. Changing the enable, polarity or mode configuration also disarms the detector. This stops a reconfiguration from being mistaken for an edge.

Software reaches the block through a small synchronous register port. Read data is registered.

Top module: `kwi_ctrl`

## Requirements
- R1: During and after reset, all registers read 0, the status flag is clear, and `irq_out` is low.
- R2: A line whose enable bit (address 1, bit n for line n) is 0 never sets the flag, whatever it does.
- R3: Polarity bit n (address 2) selects the active sense of line n: 0 means falling edge or low level, 1 means rising edge or high level.
- R4: An enabled line that moves from its inactive to its active level sets the flag. `irq_out` rises right after the third rising clock edge that follows the pin change: two synchronizer edges, then the flag edge.
- R5: After an event, no further edge is accepted until every enabled line has been at its inactive level. Disabled lines held active do not block this re-arm.
- R6: With the mode bit set (address 0, bit 0), an enabled line held at its active level keeps the flag set. After an acknowledge, the flag is low for exactly one cycle and then sets again.
- R7: `irq_out` is high exactly when the flag is set and the interrupt-enable bit (address 0, bit 1) is 1. The flag (address 0, bit 3, read-only) can be read whatever the enable is.
- R8: Writing 1 to address 0 bit 2 clears the flag, and that bit always reads 0. An edge that arrives in the same cycle as the acknowledge still leaves the flag set.
- R9: A write that changes the enable, polarity or mode value disarms the detector. A line that becomes active only because of that change is not treated as an edge.
- R10: Register map: address 0 holds control and status, address 1 the line enables, address 2 the polarities, and address 3 reads 0. Read data appears on the edge after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pins_in | input | 8 | Asynchronous external lines |
| irq_out | output | 1 | Interrupt request |

## Verification
A pin change is visible on `irq_out` after the third rising edge. The bench checks it to be still low after two edges and high after three, sampling on falling edges. A register write takes effect at the edge that accepts it. So the one-cycle dip in level mode is checked on the falling edge right after the acknowledge edge, and the re-set on the following one. Read data is taken on the falling edge after the strobe edge. Checks for the absence of an event wait at least four cycles, so that any wrongly produced event would have reached the output.

// File: rtl/kwi_pkg.sv
package kwi_pkg;
  localparam int unsigned CTRL_MODE_BIT = 0;
  localparam int unsigned CTRL_IEN_BIT  = 1;
  localparam int unsigned CTRL_ACK_BIT  = 2;
  localparam int unsigned CTRL_FLAG_BIT = 3;

  typedef enum logic [1:0] {
    REG_CTRL     = 2'd0,
    REG_PIN_EN   = 2'd1,
    REG_POLARITY = 2'd2,
    REG_SPARE    = 2'd3
  } kwi_reg_e;

  typedef struct packed {
    logic level_mode;
    logic irq_en;
  } kwi_ctrl_t;
endpackage

// File: rtl/kwi_sync.sv
module kwi_sync #(
  parameter int unsigned WIDTH   = 8,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= {(STAGES*WIDTH){RST_VAL}};
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/kwi_detect.sv
module kwi_detect #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] smp,
  input  logic [NUM_PINS-1:0] pol,
  input  logic [NUM_PINS-1:0] pin_en,
  input  logic                level_mode,
  input  logic                hist_clr,
  input  logic                ack,
  output logic                flag_q,
  output logic                flag_nxt,
  output logic [NUM_PINS-1:0] en_act,
  output logic                armed_q,
  output logic                edge_hit
);
  logic [NUM_PINS-1:0] act;
  logic [NUM_PINS-1:0] prev_q;
  logic                all_idle;
  logic                level_hit;

  // active when sample matches polarity
  assign act       = ~(smp ^ pol);
  assign en_act    = act & pin_en;
  assign all_idle  = ~|en_act;
  assign edge_hit  = armed_q & (|(en_act & ~prev_q));
  assign level_hit = level_mode & (|en_act);
  // edge beats acknowledge; level is held off for the acknowledge cycle
  assign flag_nxt  = edge_hit | (~ack & (flag_q | level_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      if (hist_clr) begin
        prev_q  <= '1;
        armed_q <= 1'b0;
      end else begin
        prev_q <= act;
        if (edge_hit)      armed_q <= 1'b0;
        else if (all_idle) armed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/kwi_regs.sv
module kwi_regs
  import kwi_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                flag_q,
  output kwi_ctrl_t           ctrl_q,
  output logic [NUM_PINS-1:0] pin_en_q,
  output logic [NUM_PINS-1:0] pol_q,
  output logic                irq_en_nxt,
  output logic                ack_pulse,
  output logic                cfg_chg
);
  kwi_reg_e            addr;
  logic                wr_ctrl, wr_en, wr_pol, rd_req;
  kwi_ctrl_t           ctrl_nxt;
  logic [NUM_PINS-1:0] en_nxt, pol_nxt;
  logic [DATA_W-1:0]   rd_word;

  assign addr    = kwi_reg_e'(bus_addr);
  assign wr_ctrl = bus_sel & bus_wr & (addr == REG_CTRL);
  assign wr_en   = bus_sel & bus_wr & (addr == REG_PIN_EN);
  assign wr_pol  = bus_sel & bus_wr & (addr == REG_POLARITY);
  assign rd_req  = bus_sel & ~bus_wr;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (wr_ctrl) begin
      ctrl_nxt.level_mode = bus_wdata[CTRL_MODE_BIT];
      ctrl_nxt.irq_en     = bus_wdata[CTRL_IEN_BIT];
    end
  end

  assign en_nxt     = wr_en  ? bus_wdata[NUM_PINS-1:0] : pin_en_q;
  assign pol_nxt    = wr_pol ? bus_wdata[NUM_PINS-1:0] : pol_q;
  assign ack_pulse  = wr_ctrl & bus_wdata[CTRL_ACK_BIT];
  assign irq_en_nxt = ctrl_nxt.irq_en;
  assign cfg_chg    = (ctrl_nxt.level_mode != ctrl_q.level_mode) |
                      (en_nxt != pin_en_q) | (pol_nxt != pol_q);

  always_comb begin
    rd_word = '0;
    unique case (addr)
      REG_CTRL: begin
        rd_word[CTRL_MODE_BIT] = ctrl_q.level_mode;
        rd_word[CTRL_IEN_BIT]  = ctrl_q.irq_en;
        rd_word[CTRL_FLAG_BIT] = flag_q;
      end
      REG_PIN_EN:   rd_word[NUM_PINS-1:0] = pin_en_q;
      REG_POLARITY: rd_word[NUM_PINS-1:0] = pol_q;
      default:      rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      pin_en_q  <= '0;
      pol_q     <= '0;
      bus_rdata <= '0;
    end else begin
      ctrl_q   <= ctrl_nxt;
      pin_en_q <= en_nxt;
      pol_q    <= pol_nxt;
      if (rd_req) bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/kwi_ctrl.sv
module kwi_ctrl
  import kwi_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic                irq_out
);
  kwi_ctrl_t           ctrl_q;
  logic [NUM_PINS-1:0] pin_en_q, pol_q, smp, en_act;
  logic                ien_q, ien_nxt, mode_q;
  logic                ack_pulse, cfg_chg;
  logic                flag_q, flag_nxt, armed_q, edge_hit;

  assign ien_q  = ctrl_q.irq_en;
  assign mode_q = ctrl_q.level_mode;

  kwi_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .q(smp)
  );

  kwi_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_q(flag_q), .ctrl_q(ctrl_q), .pin_en_q(pin_en_q), .pol_q(pol_q),
    .irq_en_nxt(ien_nxt), .ack_pulse(ack_pulse), .cfg_chg(cfg_chg)
  );

  kwi_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk(clk), .rst(rst), .smp(smp), .pol(pol_q), .pin_en(pin_en_q),
    .level_mode(mode_q), .hist_clr(cfg_chg), .ack(ack_pulse),
    .flag_q(flag_q), .flag_nxt(flag_nxt), .en_act(en_act),
    .armed_q(armed_q), .edge_hit(edge_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= flag_nxt & ien_nxt;
  end
endmodule

// File: rtl/kwi_ctrl_chk.sv
module kwi_ctrl_chk #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned DATA_W   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_sel,
  input logic                bus_wr,
  input logic [1:0]          bus_addr,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic                irq_out,
  input logic                flag_q,
  input logic                ien_q,
  input logic                mode_q,
  input logic                ack_pulse,
  input logic                edge_hit,
  input logic                armed_q,
  input logic [NUM_PINS-1:0] en_act
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && !irq_out && !flag_q && !ien_q));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (flag_q && ien_q));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_pulse && !edge_hit) |=> !flag_q);

  // R8
  ack_rdzero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && !bus_wr && bus_addr == 2'd0) |-> !bus_rdata[2]);

  // R5
  rearm_block_chk: assert property (@(posedge clk) disable iff (rst)
    edge_hit |=> !armed_q);

  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(|en_act));

  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q && (|en_act) && !ack_pulse) |=> flag_q);
endmodule

bind kwi_ctrl kwi_ctrl_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_kwi_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .flag_q(flag_q), .ien_q(ien_q), .mode_q(mode_q), .ack_pulse(ack_pulse),
  .edge_hit(edge_hit), .armed_q(armed_q), .en_act(en_act)
);

// File: tb/kwi_ctrl_bench.sv
`timescale 1ns/1ps
module kwi_ctrl_bench;
  localparam logic [7:0] MODE = 8'h01, IEN = 8'h02, ACK = 8'h04, FLAG = 8'h08;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] pins = 8'hFF;
  logic       irq_out;
  int         vectors = 0, miscompares = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  kwi_ctrl u_kwi_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_in(pins), .irq_out(irq_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    tick(4);
    rst = 1'b0;
    // R1 and R10: reset values and spare address
    chk("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    rd(2'd0, r); chk("R1 ctrl reset", r, 8'h00);
    rd(2'd1, r); chk("R1 enable reset", r, 8'h00);
    rd(2'd2, r); chk("R1 polarity reset", r, 8'h00);
    rd(2'd3, r); chk("R10 spare reads 0", r, 8'h00);

    // R2 R3 R4 R5: sweep of every line and both polarities in edge mode
    for (int p = 0; p < 8; p++) begin
      for (int pl = 0; pl < 2; pl++) begin
        int q;
        q = (p + 1) % 8;
        pins = pl[0] ? 8'h00 : 8'hFF;
        wr(2'd1, 8'(1 << p));
        wr(2'd2, pl[0] ? 8'(1 << p) : 8'h00);
        rd(2'd1, r); chk("R10 enable readback", r, 8'(1 << p));
        tick(4);
        wr(2'd0, IEN | ACK);
        tick(2);
        chk("R4 idle before edge", {7'd0, irq_out}, 8'h00);
        pins[p] = pl[0];
        tick(2);
        chk("R4 not yet after two edges", {7'd0, irq_out}, 8'h00);
        tick(1);
        chk("R3 R4 edge raises irq", {7'd0, irq_out}, 8'h01);
        rd(2'd0, r); chk("R7 flag readback", r, IEN | FLAG);
        wr(2'd0, IEN | ACK);
        tick(3);
        chk("R5 held line no refire", {7'd0, irq_out}, 8'h00);
        pins[q] = ~pins[q]; tick(4);
        pins[q] = ~pins[q]; tick(4);
        chk("R2 disabled line ignored", {7'd0, irq_out}, 8'h00);
        pins[p] = ~pl[0];
        tick(4);
      end
    end

    // R5: re-arm needs all enabled lines inactive; disabled line 5 held active
    pins = 8'hDF;
    wr(2'd2, 8'h00); wr(2'd1, 8'h03); tick(4);
    wr(2'd0, IEN | ACK); tick(2);
    pins[0] = 1'b0; tick(4);
    chk("R5 first edge", {7'd0, irq_out}, 8'h01);
    wr(2'd0, IEN | ACK);
    pins[1] = 1'b0; tick(4);
    chk("R5 blocked while line0 active", {7'd0, irq_out}, 8'h00);
    pins[0] = 1'b1; tick(4);
    chk("R5 blocked while line1 active", {7'd0, irq_out}, 8'h00);
    pins[1] = 1'b1; tick(4);
    pins[1] = 1'b0; tick(4);
    chk("R5 rearmed despite disabled line", {7'd0, irq_out}, 8'h01);
    pins = 8'hFF; tick(4);

    // R7: flag visible with interrupt disabled; irq follows enable
    wr(2'd0, ACK); tick(2);
    pins[0] = 1'b0; tick(4);
    chk("R7 irq masked", {7'd0, irq_out}, 8'h00);
    rd(2'd0, r); chk("R7 flag set while masked", r, FLAG);
    wr(2'd0, IEN);
    chk("R7 irq on enable", {7'd0, irq_out}, 8'h01);
    // R8: acknowledge clears, ack bit reads 0
    wr(2'd0, IEN | ACK);
    chk("R8 ack clears irq", {7'd0, irq_out}, 8'h00);
    rd(2'd0, r); chk("R8 ack reads zero", r, IEN);
    pins[0] = 1'b1; tick(4);

    // R8: edge in the acknowledge cycle wins
    pins[0] = 1'b0; tick(2);
    wr(2'd0, IEN | ACK);
    chk("R8 edge beats ack", {7'd0, irq_out}, 8'h01);
    rd(2'd0, r); chk("R8 flag kept", r, IEN | FLAG);
    pins[0] = 1'b1; tick(4);

    // R6: level mode on line 3, high active
    pins = 8'hF7;
    wr(2'd1, 8'h08); wr(2'd2, 8'h08);
    wr(2'd0, MODE | IEN | ACK); tick(4);
    wr(2'd0, MODE | IEN | ACK); tick(1);
    chk("R6 idle level mode", {7'd0, irq_out}, 8'h00);
    pins[3] = 1'b1; tick(3);
    chk("R6 level raises irq", {7'd0, irq_out}, 8'h01);
    wr(2'd0, MODE | IEN | ACK);
    chk("R6 dip after ack", {7'd0, irq_out}, 8'h00);
    tick(1);
    chk("R6 reasserts next cycle", {7'd0, irq_out}, 8'h01);
    pins[3] = 1'b0; tick(4);
    wr(2'd0, MODE | IEN | ACK); tick(2);
    chk("R6 stays clear when inactive", {7'd0, irq_out}, 8'h00);

    // R9: polarity change making a line active is not an edge
    pins = 8'hFF;
    wr(2'd0, IEN); wr(2'd1, 8'h10); wr(2'd2, 8'h00); tick(4);
    wr(2'd0, IEN | ACK); tick(2);
    wr(2'd2, 8'h10); tick(4);
    chk("R9 no edge from polarity change", {7'd0, irq_out}, 8'h00);
    pins[4] = 1'b0; tick(4);
    pins[4] = 1'b1; tick(4);
    chk("R9 R3 rising edge after rearm", {7'd0, irq_out}, 8'h01);
    rd(2'd2, r); chk("R10 polarity readback", r, 8'h10);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule